// File: doc/BRIEF.md
# Packed SIMD Saturating Left Shifter

This block shifts every element of a packed vector left by an immediate count and clamps each element to the range of its result type on its own. The vector is either one 64-bit half or two 64-bit halves (128 bits). Elements are 8, 16, 32 or 64 bits wide. One long-element bit and a six-bit immediate carry both the element width and the shift count: the width is set by the position of the leading one in the immediate, and the count is the bits below it.

Three signedness modes are available. Signed in, signed out clamps to the signed range. Unsigned in, unsigned out clamps to the unsigned range. Signed in, unsigned out reads the lanes as signed and clamps the results to the unsigned range, so every negative lane becomes zero. The result is registered one clock after the input strobe and comes with an output strobe. A sticky flag records any lane that clamped, and a per-operation flag marks encodings that cannot be decoded.

Top module: `simd_sat_lshift`

## Requirements
- R1: An operation accepted with `in_valid` high sets `out_valid` high for exactly one cycle, on the clock edge that ends the accepting cycle. With no strobe, `out_valid` is low.
- R2: When `l_bit`=1, elements are 64 bits wide and the count is `imm6`. When `l_bit`=0 and `imm6[5]`=1, elements are 32 bits wide and the count is `imm6[4:0]`. When `l_bit`=0 and `imm6[5:4]`=01, elements are 16 bits wide and the count is `imm6[3:0]`. When `l_bit`=0 and `imm6[5:3]`=001, elements are 8 bits wide and the count is `imm6[2:0]`.
- R3: With `u_bit`=0 and `op_bit`=1, each lane is signed. It becomes its shifted value when that value fits the signed range. Otherwise it becomes the signed maximum for a non-negative input or the signed minimum for a negative input, and the lane counts as saturated.
- R4: With `u_bit`=1 and `op_bit`=0, each lane is read as signed and clamped to the unsigned range. A negative lane gives zero and counts as saturated. A non-negative lane gives its shifted value, or all ones (saturated) if the shifted value does not fit.
- R5: With `u_bit`=1 and `op_bit`=1, each lane is unsigned. It gives its shifted value, or all ones (saturated) when set bits are shifted out.
- R6: `u_bit`=0 with `op_bit`=0 is illegal. `illegal` is high together with `out_valid` for that operation, `out_vec` keeps its previous value, and the sticky flag is not set.
- R7: `l_bit`=0 with `imm6[5:3]`=000 is illegal, with the same effects as in R6. `illegal` is low for every legal operation.
- R8: With `q_sel`=1, both 64-bit halves of `op_vec` are processed. With `q_sel`=0, only `op_vec[63:0]` is processed, `out_vec[127:64]` is zero, and the upper half cannot set the sticky flag.
- R9: `sat_sticky` goes high on the result edge of a legal operation in which any processed lane saturated. It stays high until cleared.
- R10: `sat_clr` high clears `sat_sticky` on the next edge. A saturating operation accepted in the same cycle sets it again.
- R11: A synchronous active-high `rst` clears `out_valid`, `out_vec`, `sat_sticky` and `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| q_sel | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| u_bit | input | 1 | Signedness select, upper bit |
| op_bit | input | 1 | Signedness select, lower bit |
| l_bit | input | 1 | Forces 64-bit elements |
| imm6 | input | 6 | Element width and shift count |
| op_vec | input | 128 | Operand vector |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result strobe |
| out_vec | output | 128 | Result vector |
| sat_sticky | output | 1 | Sticky saturation flag |
| illegal | output | 1 | Undecodable encoding for this result |

## Verification
The bench sweeps every element width, every legal count and every mode. It uses operands that put zero, one, minus one and both signed extremes into each lane, together with pseudo-random lanes. A design that tested overflow on too few shifted-out bits would pass wrong values where a single bit crosses into the sign. A design that picked the wrong clamp direction would give the maximum for negative lanes. In the mixed mode, a design that let negative inputs through would return non-zero values. The bench also issues both kinds of illegal encoding and checks that the previous result is held. It checks that a 64-bit operation zeroes the upper half and ignores saturation there, and that the sticky flag survives later clean operations and falls only on a clear.

// File: rtl/simd_shl_pkg.sv
package simd_shl_pkg;

  // Element width selector, also used as an index into per-width results.
  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_e;

  typedef enum logic [1:0] {
    MD_SS  = 2'd0,  // signed in, signed out
    MD_SU  = 2'd1,  // signed in, unsigned out
    MD_UU  = 2'd2,  // unsigned in, unsigned out
    MD_BAD = 2'd3
  } mode_e;

  typedef struct packed {
    esz_e       esz;
    logic [5:0] shamt;
    mode_e      mode;
    logic       bad;
  } dec_t;

endpackage

// File: rtl/simd_shl_decode.sv
module simd_shl_decode
  import simd_shl_pkg::*;
(
  input  logic       l_bit,
  input  logic       u_bit,
  input  logic       op_bit,
  input  logic [5:0] imm6,
  output dec_t       dec
);

  logic size_bad;

  always_comb begin
    size_bad  = 1'b0;
    dec.esz   = ESZ_8;
    dec.shamt = 6'd0;
    if (l_bit) begin
      dec.esz   = ESZ_64;
      dec.shamt = imm6;
    end else if (imm6[5]) begin
      dec.esz   = ESZ_32;
      dec.shamt = {1'b0, imm6[4:0]};
    end else if (imm6[4]) begin
      dec.esz   = ESZ_16;
      dec.shamt = {2'b00, imm6[3:0]};
    end else if (imm6[3]) begin
      dec.esz   = ESZ_8;
      dec.shamt = {3'b000, imm6[2:0]};
    end else begin
      size_bad  = 1'b1;
    end

    unique case ({u_bit, op_bit})
      2'b01:   dec.mode = MD_SS;
      2'b10:   dec.mode = MD_SU;
      2'b11:   dec.mode = MD_UU;
      default: dec.mode = MD_BAD;
    endcase

    dec.bad = size_bad || (dec.mode == MD_BAD);
  end

endmodule

// File: rtl/simd_shl_lane.sv
module simd_shl_lane
  import simd_shl_pkg::*;
#(
  parameter int W = 8,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [SW-1:0] sh,
  input  mode_e         mode,
  output logic [W-1:0]  y,
  output logic          sat
);

  localparam logic [W-1:0] MAX_S = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_S = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_U = {W{1'b1}};

  logic [2*W-1:0] ext;
  logic [2*W-1:0] shf;
  logic           src_signed;
  logic           fits_s;
  logic           fits_u;

  always_comb begin
    src_signed = (mode != MD_UU);
    ext        = src_signed ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    shf        = ext << sh;
    // Signed fit: every bit from the new sign upward agrees.
    fits_s     = (&shf[2*W-1:W-1]) || !(|shf[2*W-1:W-1]);
    // Unsigned fit: nothing lands above the lane.
    fits_u     = !(|shf[2*W-1:W]);

    y   = a;
    sat = 1'b0;
    unique case (mode)
      MD_SS: begin
        sat = !fits_s;
        y   = fits_s ? shf[W-1:0] : (a[W-1] ? MIN_S : MAX_S);
      end
      MD_SU: begin
        if (a[W-1]) begin
          sat = 1'b1;
          y   = '0;
        end else begin
          sat = !fits_u;
          y   = fits_u ? shf[W-1:0] : MAX_U;
        end
      end
      MD_UU: begin
        sat = !fits_u;
        y   = fits_u ? shf[W-1:0] : MAX_U;
      end
      default: begin
        sat = 1'b0;
        y   = a;
      end
    endcase
  end

endmodule

// File: rtl/simd_shl_half.sv
module simd_shl_half
  import simd_shl_pkg::*;
#(
  parameter int HW = 64,
  localparam int NSZ = 4
) (
  input  logic [HW-1:0] a,
  input  esz_e          esz,
  input  logic [5:0]    shamt,
  input  mode_e         mode,
  output logic [HW-1:0] y,
  output logic          sat
);

  logic [NSZ-1:0][HW-1:0] y_by_sz;
  logic [NSZ-1:0]         sat_by_sz;

  for (genvar z = 0; z < NSZ; z++) begin : g_sz
    localparam int LW = 8 << z;
    localparam int NL = HW / LW;
    localparam int LSW = $clog2(LW);
    logic [HW-1:0] ys;
    logic [NL-1:0] ss;

    for (genvar k = 0; k < NL; k++) begin : g_ln
      simd_shl_lane #(.W(LW)) u_lane (
        .a    (a[k*LW +: LW]),
        .sh   (shamt[LSW-1:0]),
        .mode (mode),
        .y    (ys[k*LW +: LW]),
        .sat  (ss[k])
      );
    end

    assign y_by_sz[z]   = ys;
    assign sat_by_sz[z] = |ss;
  end

  assign y   = y_by_sz[esz];
  assign sat = sat_by_sz[esz];

endmodule

// File: rtl/simd_sat_lshift.sv
module simd_sat_lshift
  import simd_shl_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int HALVES = 2,
  localparam int VEC_W = HALF_W * HALVES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             q_sel,
  input  logic             u_bit,
  input  logic             op_bit,
  input  logic             l_bit,
  input  logic [5:0]       imm6,
  input  logic [VEC_W-1:0] op_vec,
  input  logic             sat_clr,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_vec,
  output logic             sat_sticky,
  output logic             illegal
);

  dec_t               dec;
  logic [VEC_W-1:0]   y_full;
  logic [HALVES-1:0]  sat_h;

  simd_shl_decode u_dec (
    .l_bit  (l_bit),
    .u_bit  (u_bit),
    .op_bit (op_bit),
    .imm6   (imm6),
    .dec    (dec)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic              active;
    logic [HALF_W-1:0] yh;
    logic              sh;

    assign active = (h == 0) || q_sel;

    simd_shl_half #(.HW(HALF_W)) u_half (
      .a     (op_vec[h*HALF_W +: HALF_W]),
      .esz   (dec.esz),
      .shamt (dec.shamt),
      .mode  (dec.mode),
      .y     (yh),
      .sat   (sh)
    );

    assign y_full[h*HALF_W +: HALF_W] = active ? yh : '0;
    assign sat_h[h]                   = active && sh;
  end

  logic take;
  assign take = in_valid && !dec.bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_vec    <= '0;
      sat_sticky <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      illegal    <= in_valid && dec.bad;
      if (take) out_vec <= y_full;
      sat_sticky <= (sat_sticky && !sat_clr) || (take && (|sat_h));
    end
  end

endmodule

// File: rtl/simd_sat_lshift_chk.sv
module simd_sat_lshift_chk #(
  parameter int HALF_W = 64,
  parameter int VEC_W  = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             q_sel,
  input logic             sat_clr,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_vec,
  input logic             sat_sticky,
  input logic             illegal
);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_illegal_with_valid_R6: assert property (@(posedge clk) disable iff (rst)
    illegal |-> out_valid);

  assert_illegal_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> $stable(out_vec));

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !q_sel) |=> (illegal || (out_vec[VEC_W-1:HALF_W] == '0)));

  assert_sticky_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (sat_sticky && !sat_clr) |=> sat_sticky);

  assert_sticky_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sat_sticky) |-> (out_valid && !illegal));

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (sat_clr && !in_valid) |=> !sat_sticky);

endmodule

bind simd_sat_lshift simd_sat_lshift_chk #(
  .HALF_W (HALF_W),
  .VEC_W  (VEC_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .q_sel      (q_sel),
  .sat_clr    (sat_clr),
  .out_valid  (out_valid),
  .out_vec    (out_vec),
  .sat_sticky (sat_sticky),
  .illegal    (illegal)
);

// File: tb/simd_sat_lshift_tb_top.sv
module simd_sat_lshift_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         q_sel = 1'b0;
  logic         u_bit = 1'b0;
  logic         op_bit = 1'b1;
  logic         l_bit = 1'b0;
  logic [5:0]   imm6 = 6'd8;
  logic [127:0] op_vec = '0;
  logic         sat_clr = 1'b0;
  logic         out_valid;
  logic [127:0] out_vec;
  logic         sat_sticky;
  logic         illegal;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;  // 200 MHz

  simd_sat_lshift dut_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .q_sel      (q_sel),
    .u_bit      (u_bit),
    .op_bit     (op_bit),
    .l_bit      (l_bit),
    .imm6       (imm6),
    .op_vec     (op_vec),
    .sat_clr    (sat_clr),
    .out_valid  (out_valid),
    .out_vec    (out_vec),
    .sat_sticky (sat_sticky),
    .illegal    (illegal)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    logic [63:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  // Arithmetic reference: md 0 = signed/signed, 1 = signed/unsigned, 2 = unsigned/unsigned
  function automatic void model(input logic [63:0] a, input int w, input int sh,
                                input int md, output logic [63:0] r, output logic s);
    logic [63:0] mask;
    logic [63:0] raw;
    logic signed [129:0] v, p, hi, lo, rr;
    r = '0;
    s = 1'b0;
    mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    for (int k = 0; k < 64 / w; k++) begin
      raw = (a >> (k * w)) & mask;
      v = $signed({66'd0, raw});
      if (md != 2 && raw[w-1]) v = v - (130'sd1 <<< w);
      p = v * (130'sd1 <<< sh);
      if (md == 0) begin
        hi = (130'sd1 <<< (w - 1)) - 130'sd1;
        lo = -(130'sd1 <<< (w - 1));
      end else begin
        hi = (130'sd1 <<< w) - 130'sd1;
        lo = 130'sd0;
      end
      if (p > hi) begin
        rr = hi; s = 1'b1;
      end else if (p < lo) begin
        rr = lo; s = 1'b1;
      end else begin
        rr = p;
      end
      r = r | ((rr[63:0] & mask) << (k * w));
    end
  endfunction

  function automatic logic [63:0] corner_half(input int w, input int rot);
    logic [63:0] h;
    logic [63:0] lane;
    logic [63:0] mask;
    h = '0;
    mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    for (int k = 0; k < 64 / w; k++) begin
      case ((k + rot) % 5)
        0: lane = 64'd0;
        1: lane = 64'd1;
        2: lane = mask;
        3: lane = mask >> 1;
        default: lane = (mask >> 1) + 64'd1;
      endcase
      h = h | ((lane & mask) << (k * w));
    end
    return h;
  endfunction

  task automatic run_op(input logic q, input logic u, input logic o, input logic l,
                        input logic [5:0] im, input logic [127:0] v, input logic clr);
    @(negedge clk);
    in_valid = 1'b1;
    q_sel = q; u_bit = u; op_bit = o; l_bit = l; imm6 = im;
    op_vec = v; sat_clr = clr;
    @(negedge clk);
    in_valid = 1'b0;
    sat_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0]  r0, r1;
    logic         s0, s1;
    logic [127:0] v, exp_v, prev;
    logic         q;
    int           cnt;
    string        tag;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_vec == '0 && sat_sticky == 1'b0 && illegal == 1'b0,
          "R11 reset state", {out_valid, sat_sticky, illegal}, 128'd0);

    // R1 strobe timing
    run_op(1'b0, 1'b1, 1'b1, 1'b0, 6'd8, 128'h5, 1'b1);
    check(out_valid == 1'b1, "R1 out_valid after strobe", 128'(out_valid), 128'd1);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid single pulse", 128'(out_valid), 128'd0);

    // Sweep: R2, R3, R4, R5, R8 with sticky cleared each op (R10)
    cnt = 0;
    for (int z = 0; z < 4; z++) begin
      for (int md = 0; md < 3; md++) begin
        for (int sh = 0; sh < (8 << z); sh++) begin
          for (int p = 0; p < 3; p++) begin
            int w;
            logic [5:0] im;
            w = 8 << z;
            im = (z == 3) ? 6'(sh) : 6'(w + sh);
            if (p == 0) begin
              v = {corner_half(w, sh + 2), corner_half(w, sh)};
            end else begin
              rs = next_rand(rs);
              v[63:0] = rs;
              rs = next_rand(rs);
              v[127:64] = rs;
              if (p == 2) v = v >> (cnt % 7);
            end
            q = cnt[0];
            cnt++;
            run_op(q, (md != 0), (md != 1), (z == 3), im, v, 1'b1);
            model(v[63:0], w, sh, md, r0, s0);
            model(v[127:64], w, sh, md, r1, s1);
            exp_v = {q ? r1 : 64'd0, r0};
            tag = (md == 0) ? "R3 R2 R8" : (md == 1) ? "R4 R2 R8" : "R5 R2 R8";
            check(out_vec == exp_v && out_valid && !illegal, tag, out_vec, exp_v);
            check(sat_sticky == (s0 || (q && s1)), "R9 R10 sticky per op",
                  128'(sat_sticky), 128'(s0 || (q && s1)));
          end
        end
      end
    end

    // R8: upper half saturation ignored in 64-bit mode
    run_op(1'b0, 1'b1, 1'b1, 1'b0, 6'd15, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101}, 1'b1);
    check(sat_sticky == 1'b0 && out_vec == {64'd0, 64'h8080_8080_8080_8080},
          "R8 upper half ignored", out_vec, {64'd0, 64'h8080_8080_8080_8080});

    // R9: set, then hold through a clean op
    run_op(1'b1, 1'b0, 1'b1, 1'b0, 6'd9, {64'd0, 64'h0000_0000_0000_0040}, 1'b0);
    check(sat_sticky == 1'b1 && out_vec[7:0] == 8'h7F, "R9 sticky set", out_vec, 128'h7F);
    run_op(1'b1, 1'b1, 1'b1, 1'b0, 6'd8, 128'h1, 1'b0);
    check(sat_sticky == 1'b1, "R9 sticky held", 128'(sat_sticky), 128'd1);

    // R10: clear alone
    @(negedge clk);
    sat_clr = 1'b1;
    @(negedge clk);
    sat_clr = 1'b0;
    check(sat_sticky == 1'b0, "R10 clear", 128'(sat_sticky), 128'd0);

    // R6: illegal mode, result held, sticky untouched
    run_op(1'b1, 1'b1, 1'b1, 1'b1, 6'd4, {64'h1234, 64'h0ABC}, 1'b0);
    prev = out_vec;
    run_op(1'b1, 1'b0, 1'b0, 1'b0, 6'd15, {128{1'b1}} >> 1, 1'b0);
    check(illegal == 1'b1 && out_valid == 1'b1, "R6 illegal flag", 128'(illegal), 128'd1);
    check(out_vec == prev && sat_sticky == 1'b0, "R6 result held", out_vec, prev);

    // R7: illegal width field with L=0, result held
    run_op(1'b0, 1'b0, 1'b1, 1'b0, 6'd5, 128'h7F, 1'b0);
    check(illegal == 1'b1 && out_vec == prev && sat_sticky == 1'b0,
          "R7 illegal width held", out_vec, prev);
    @(negedge clk);
    check(illegal == 1'b0 && out_valid == 1'b0, "R7 illegal clears", 128'(illegal), 128'd0);

    // R7: L=1 with zero immediate is legal
    run_op(1'b0, 1'b0, 1'b1, 1'b1, 6'd0, 128'h8000_0000_0000_0000, 1'b0);
    check(illegal == 1'b0 && out_vec == 128'h8000_0000_0000_0000,
          "R7 legal 64-bit zero count", out_vec, 128'h8000_0000_0000_0000);

    // R11: reset mid-run
    run_op(1'b0, 1'b1, 1'b1, 1'b0, 6'd15, 128'hFF, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(out_vec == '0 && sat_sticky == 1'b0 && illegal == 1'b0,
          "R11 reset clears", out_vec, 128'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule